// File: doc/BRIEF.md
# Emulated Single-Port PHY Management Slave

This block lets a MAC's station-management port talk to a switch as though a single-port PHY were attached. It is a clause 22 MDIO slave. It samples MDC and MDIO in the system clock domain, decodes read and write frames addressed to its strap address, and serves a small register bank. The bank holds basic control, basic status, the two identifier words, the auto-negotiation advertisement and the link-partner ability. Control bits drive the loopback, isolate, collision-test, speed and duplex outputs.

No real link partner exists, so auto-negotiation is emulated. A start runs a fixed-length countdown. When it ends, the block takes the best mode that the advertisement register and a fixed partner-ability parameter have in common, and reports it. The result shows in the status and link-partner registers and on the speed and duplex pins. An unmodified MAC driver sees negotiation finish with the same result every time for the same settings.

Top module: `vphy_mdio_emu`

## Requirements
- R1: A frame is accepted after at least 32 consecutive ones on MDIO (each sampled on a rising MDC edge), followed by start bits 0 then 1, opcode 10 (read) or 01 (write), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits, all sent MSB first. A write frame updates the addressed register.
- R2: A frame whose PHY address differs from the PHY_ADDR parameter leaves every register unchanged, and the block never enables its MDIO driver during that frame.
- R3: On an accepted read, the block drives 0 during the second turnaround bit and then drives the 16 register bits MSB first. Outside that window mdio_oe is low, and mdio_oe and mdio_o change only after a rising MDC edge.
- R4: Register 2 reads ID_HI and register 3 reads ID_LO. Register 1 (status) reads 0x780D, plus bit 5 (0x0020) while auto-negotiation is complete. Writes to registers 1, 2, 3 and 5 are ignored, and any address above 5 reads 0x0000.
- R5: Control register 0 bit 14 drives lpbk, bit 10 drives iso and bit 7 drives coltest. These bits and bits 13, 12 and 8 read back as written.
- R6: While control bit 12 (auto-negotiation enable) is 0, spd_100 follows control bit 13 and fdx follows control bit 8, and status bit 5 reads 0.
- R7: Control bit 9 (restart) always reads 0. Writing it as 1 together with bit 12 = 1, or changing bit 12 from 0 to 1, starts a negotiation. Status bit 5 is 0 from the start until AN_CYCLES clock cycles later, and is then set.
- R8: Advertisement register 4 holds writable bits 8..5 (bit 8 = 100 full, 7 = 100 half, 6 = 10 full, 5 = 10 half), reads 0x0001 in bits 4..0 and resets to 0x01E1. A completed negotiation picks the highest mode set in both register 4 and PARTNER_ABIL (100 full > 100 half > 10 full > 10 half), or 10 half when they share none. While bit 12 is 1 this choice drives spd_100 and fdx. Register 5 then reads 0x4001 with the chosen mode's bit among bits 8..5.
- R9: After the hardware reset, control reads 0x3100 (100 Mb/s, full duplex, auto-negotiation on), all other outputs are low, and a negotiation runs to completion without any register access.
- R10: Writing control bit 15 as 1 restores the default control and advertisement values, reads back as 0, and restarts negotiation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; MDC and MDIO are oversampled on it |
| rst_n | input | 1 | Active-low hardware reset; also restarts negotiation |
| mdc | input | 1 | Management clock from the MAC |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO driver enable |
| spd_100 | output | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| fdx | output | 1 | 1 selects full duplex |
| lpbk | output | 1 | Loopback request |
| iso | output | 1 | Isolate request |
| coltest | output | 1 | Collision-test request |

## Verification
The bench builds the block with PHY_ADDR = 9, PARTNER_ABIL = 4'b0110 and AN_CYCLES = 1500. With a partner that offers only the two middle modes, a random advertisement can resolve to any of three outcomes: 100 half, 10 full, or the fallback with no common mode. With a countdown longer than the time to the status latch of one management read, the bench can see the complete bit low right after a restart and high once the countdown has run out.

// File: rtl/vphy_pkg.sv
package vphy_pkg;

   // register addresses decoded by a standard driver
   localparam logic [4:0] RA_CTRL = 5'd0;
   localparam logic [4:0] RA_STAT = 5'd1;
   localparam logic [4:0] RA_IDHI = 5'd2;
   localparam logic [4:0] RA_IDLO = 5'd3;
   localparam logic [4:0] RA_ADV  = 5'd4;
   localparam logic [4:0] RA_LP   = 5'd5;

   // ability field order (register bits 8..5)
   localparam int AB_100F = 3;
   localparam int AB_100H = 2;
   localparam int AB_10F  = 1;
   localparam int AB_10H  = 0;

   typedef enum logic [1:0] {MF_PRE, MF_HDR, MF_TA, MF_DATA} mf_state_t;
   typedef enum logic [1:0] {NG_IDLE, NG_RUN, NG_DONE} ng_state_t;

   typedef struct packed {
      logic spd;
      logic dup;
   } mode_t;

   // keep only the most preferred shared ability; empty means none
   function automatic logic [3:0] pick_best(input logic [3:0] common);
      logic [3:0] r;
      r = 4'b0000;
      if (common[AB_100F])      r[AB_100F] = 1'b1;
      else if (common[AB_100H]) r[AB_100H] = 1'b1;
      else if (common[AB_10F])  r[AB_10F]  = 1'b1;
      else if (common[AB_10H])  r[AB_10H]  = 1'b1;
      return r;
   endfunction

   function automatic mode_t mode_of(input logic [3:0] best);
      mode_t m;
      m.spd = best[AB_100F] | best[AB_100H];
      m.dup = best[AB_100F] | best[AB_10F];
      return m;
   endfunction

endpackage

// File: rtl/vphy_mdio_frame.sv
module vphy_mdio_frame
   import vphy_pkg::*;
#(
   parameter logic [4:0] PHY_ADDR    = 5'd1,
   parameter int         SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mdc,
   input  logic        mdio_i,
   input  logic [15:0] rd_data,
   output logic [4:0]  reg_addr,
   output logic        wr_en,
   output logic [15:0] wr_data,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        frm_read,
   output logic        mdc_rise
);

   localparam int LAST = SYNC_STAGES - 1;
   localparam int HDR_BITS = 13;

   logic [SYNC_STAGES-1:0] mdc_s, mdi_s;
   logic mdc_q;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  mdc_s[0] <= 1'b0;
                  mdi_s[0] <= 1'b1;
               end else begin
                  mdc_s[0] <= mdc;
                  mdi_s[0] <= mdio_i;
               end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  mdc_s[g] <= 1'b0;
                  mdi_s[g] <= 1'b1;
               end else begin
                  mdc_s[g] <= mdc_s[g-1];
                  mdi_s[g] <= mdi_s[g-1];
               end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mdc_q <= 1'b0;
      else        mdc_q <= mdc_s[LAST];

   assign mdc_rise = mdc_s[LAST] & ~mdc_q;

   logic        bit_in;
   assign bit_in = mdi_s[LAST];

   mf_state_t         st;
   logic [5:0]        ones;
   logic [3:0]        cnt;
   logic [HDR_BITS-2:0] hdr;
   logic [HDR_BITS-1:0] hdr_full;
   logic [15:0]       sh_in, sh_out;
   logic              hdr_ok;

   assign hdr_full = {hdr, bit_in};
   assign hdr_ok   = hdr_full[12]
                   && (hdr_full[11:10] == 2'b10 || hdr_full[11:10] == 2'b01)
                   && (hdr_full[9:5] == PHY_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= MF_PRE;
         ones     <= '0;
         cnt      <= '0;
         hdr      <= '0;
         sh_in    <= '0;
         sh_out   <= '0;
         reg_addr <= '0;
         frm_read <= 1'b0;
         mdio_o   <= 1'b0;
         mdio_oe  <= 1'b0;
         wr_en    <= 1'b0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (mdc_rise) begin
            case (st)
               MF_PRE: begin
                  if (bit_in) begin
                     if (ones != 6'd32) ones <= ones + 6'd1;
                  end else begin
                     if (ones == 6'd32) begin
                        st  <= MF_HDR;
                        cnt <= '0;
                     end
                     ones <= '0;
                  end
               end
               MF_HDR: begin
                  hdr <= hdr_full[HDR_BITS-2:0];
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'(HDR_BITS - 1)) begin
                     cnt <= '0;
                     if (hdr_ok) begin
                        st       <= MF_TA;
                        frm_read <= (hdr_full[11:10] == 2'b10);
                        reg_addr <= hdr_full[4:0];
                     end else begin
                        st <= MF_PRE;
                     end
                  end
               end
               MF_TA: begin
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd0 && frm_read) begin
                     mdio_oe <= 1'b1;
                     mdio_o  <= 1'b0;
                  end
                  if (cnt == 4'd1) begin
                     st  <= MF_DATA;
                     cnt <= '0;
                     if (frm_read) begin
                        mdio_o <= rd_data[15];
                        sh_out <= {rd_data[14:0], 1'b0};
                     end
                  end
               end
               MF_DATA: begin
                  sh_in <= {sh_in[14:0], bit_in};
                  cnt   <= cnt + 4'd1;
                  if (frm_read) begin
                     if (cnt == 4'd15) begin
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b0;
                     end else begin
                        mdio_o <= sh_out[15];
                        sh_out <= {sh_out[14:0], 1'b0};
                     end
                  end
                  if (cnt == 4'd15) begin
                     st       <= MF_PRE;
                     ones     <= '0;
                     frm_read <= 1'b0;
                     if (!frm_read) begin
                        wr_en   <= 1'b1;
                        wr_data <= {sh_in[14:0], bit_in};
                     end
                  end
               end
               default: st <= MF_PRE;
            endcase
         end
      end
   end

endmodule

// File: rtl/vphy_regbank.sv
module vphy_regbank
   import vphy_pkg::*;
#(
   parameter logic [15:0] ID_HI      = 16'h0022,
   parameter logic [15:0] ID_LO      = 16'h5A31,
   parameter bit          AN_DEFAULT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [4:0]  addr,
   input  logic [15:0] wr_data,
   input  logic        an_done,
   input  logic        lp_valid,
   input  logic [3:0]  lp_bits,
   output logic [15:0] rd_data,
   output logic        an_en,
   output logic        an_start,
   output logic        man_spd,
   output logic        man_dup,
   output logic        lpbk,
   output logic        iso,
   output logic        coltest,
   output logic [3:0]  adv
);

   localparam logic [4:0] SELECTOR = 5'b00001;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         an_en    <= AN_DEFAULT;
         man_spd  <= 1'b1;
         man_dup  <= 1'b1;
         lpbk     <= 1'b0;
         iso      <= 1'b0;
         coltest  <= 1'b0;
         adv      <= 4'hF;
         an_start <= 1'b0;
      end else begin
         an_start <= 1'b0;
         if (wr_en) begin
            case (addr)
               RA_CTRL: begin
                  if (wr_data[15]) begin
                     an_en    <= AN_DEFAULT;
                     man_spd  <= 1'b1;
                     man_dup  <= 1'b1;
                     lpbk     <= 1'b0;
                     iso      <= 1'b0;
                     coltest  <= 1'b0;
                     adv      <= 4'hF;
                     an_start <= AN_DEFAULT;
                  end else begin
                     lpbk     <= wr_data[14];
                     man_spd  <= wr_data[13];
                     an_en    <= wr_data[12];
                     iso      <= wr_data[10];
                     man_dup  <= wr_data[8];
                     coltest  <= wr_data[7];
                     an_start <= wr_data[12] & (wr_data[9] | ~an_en);
                  end
               end
               RA_ADV:  adv <= wr_data[8:5];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (addr)
         RA_CTRL: rd_data = {1'b0, lpbk, man_spd, an_en, 1'b0, iso, 1'b0,
                             man_dup, coltest, 7'b0};
         RA_STAT: rd_data = {1'b0, 4'hF, 4'h0, 1'b0, an_done, 1'b0,
                             1'b1, 1'b1, 1'b0, 1'b1};
         RA_IDHI: rd_data = ID_HI;
         RA_IDLO: rd_data = ID_LO;
         RA_ADV:  rd_data = {7'b0, adv, SELECTOR};
         RA_LP:   rd_data = lp_valid ? {2'b01, 5'b0, lp_bits, SELECTOR} : 16'h0;
         default: rd_data = 16'h0;
      endcase
   end

endmodule

// File: rtl/vphy_an_emu.sv
module vphy_an_emu
   import vphy_pkg::*;
#(
   parameter int         AN_CYCLES    = 64,
   parameter logic [3:0] PARTNER_ABIL = 4'hF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       an_en,
   input  logic       an_start,
   input  logic [3:0] adv,
   output logic       an_done,
   output logic       an_busy,
   output mode_t      res,
   output logic       lp_valid,
   output logic [3:0] lp_bits
);

   localparam int CW = $clog2(AN_CYCLES + 1);
   localparam logic [CW-1:0] CNT_END = CW'(AN_CYCLES - 1);

   ng_state_t      st;
   logic [CW-1:0]  cnt;
   logic [3:0]     best;

   assign best    = pick_best(adv & PARTNER_ABIL);
   assign an_done = (st == NG_DONE);
   assign an_busy = (st == NG_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= NG_RUN;
         cnt      <= '0;
         res      <= '0;
         lp_valid <= 1'b0;
         lp_bits  <= '0;
      end else begin
         case (st)
            NG_IDLE: if (an_start && an_en) begin
               st  <= NG_RUN;
               cnt <= '0;
            end
            NG_RUN: begin
               if (!an_en) begin
                  st <= NG_IDLE;
               end else if (an_start) begin
                  cnt <= '0;
               end else if (cnt == CNT_END) begin
                  st       <= NG_DONE;
                  res      <= mode_of(best);
                  lp_bits  <= best;
                  lp_valid <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            NG_DONE: begin
               if (!an_en) begin
                  st <= NG_IDLE;
               end else if (an_start) begin
                  st  <= NG_RUN;
                  cnt <= '0;
               end
            end
            default: st <= NG_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vphy_mdio_emu.sv
module vphy_mdio_emu
   import vphy_pkg::*;
#(
   parameter logic [4:0]  PHY_ADDR     = 5'd1,
   parameter int          SYNC_STAGES  = 2,
   parameter int          AN_CYCLES    = 64,
   parameter logic [3:0]  PARTNER_ABIL = 4'hF,
   parameter bit          AN_DEFAULT   = 1'b1,
   parameter logic [15:0] ID_HI        = 16'h0022,
   parameter logic [15:0] ID_LO        = 16'h5A31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc,
   input  logic mdio_i,
   output logic mdio_o,
   output logic mdio_oe,
   output logic spd_100,
   output logic fdx,
   output logic lpbk,
   output logic iso,
   output logic coltest
);

   initial begin
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES below 2");
      assert (AN_CYCLES >= 1)   else $fatal(1, "AN_CYCLES below 1");
   end

   logic [15:0] rd_data, wr_data;
   logic [4:0]  reg_addr;
   logic        wr_en, frm_read, mdc_rise;
   logic        an_en, an_start, man_spd, man_dup, an_done, an_busy, lp_valid;
   logic [3:0]  adv, lp_bits;
   mode_t       res;

   vphy_mdio_frame #(.PHY_ADDR(PHY_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_frame (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
      .rd_data(rd_data), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .frm_read(frm_read), .mdc_rise(mdc_rise)
   );

   vphy_regbank #(.ID_HI(ID_HI), .ID_LO(ID_LO), .AN_DEFAULT(AN_DEFAULT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr), .wr_data(wr_data),
      .an_done(an_done), .lp_valid(lp_valid), .lp_bits(lp_bits), .rd_data(rd_data),
      .an_en(an_en), .an_start(an_start), .man_spd(man_spd), .man_dup(man_dup),
      .lpbk(lpbk), .iso(iso), .coltest(coltest), .adv(adv)
   );

   vphy_an_emu #(.AN_CYCLES(AN_CYCLES), .PARTNER_ABIL(PARTNER_ABIL)) u_an (
      .clk(clk), .rst_n(rst_n), .an_en(an_en), .an_start(an_start), .adv(adv),
      .an_done(an_done), .an_busy(an_busy), .res(res),
      .lp_valid(lp_valid), .lp_bits(lp_bits)
   );

   assign spd_100 = an_en ? res.spd : man_spd;
   assign fdx     = an_en ? res.dup : man_dup;

endmodule

// File: rtl/vphy_mdio_emu_chk.sv
module vphy_mdio_emu_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mdc_rise,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic        frm_read,
   input logic        wr_en,
   input logic [4:0]  reg_addr,
   input logic [15:0] wr_data,
   input logic        an_en,
   input logic        an_done,
   input logic        an_busy
);

   // R3
   pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mdc_rise |=> ($stable(mdio_oe) && $stable(mdio_o)));

   // R3
   drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> frm_read);

   // R7
   restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == 5'd0 && wr_data[12] && wr_data[9] && !wr_data[15])
      |-> ##2 !an_done);

   // R6
   an_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(an_en) |=> !an_done);

   // R7
   done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(an_done) |-> $past(an_busy));

endmodule

bind vphy_mdio_emu vphy_mdio_emu_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdio_o(mdio_o),
   .mdio_oe(mdio_oe), .frm_read(frm_read), .wr_en(wr_en), .reg_addr(reg_addr),
   .wr_data(wr_data), .an_en(an_en), .an_done(an_done), .an_busy(an_busy)
);

// File: tb/sim_vphy_mdio_emu.sv
`timescale 1ns/1ps
module sim_vphy_mdio_emu;

   localparam logic [4:0] ADDR    = 5'd9;
   localparam logic [3:0] PARTNER = 4'b0110;
   localparam int         NCYC    = 1500;
   localparam logic [15:0] IDH    = 16'h0022;
   localparam logic [15:0] IDL    = 16'h5A31;

   logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0;
   logic m_drv = 1'b1, m_val = 1'b1;
   logic mdio_o, mdio_oe, spd_100, fdx, lpbk, iso, coltest, line;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   assign line = mdio_oe ? mdio_o : (m_drv ? m_val : 1'b1);

   vphy_mdio_emu #(.PHY_ADDR(ADDR), .AN_CYCLES(NCYC), .PARTNER_ABIL(PARTNER),
                   .ID_HI(IDH), .ID_LO(IDL)) u0 (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .spd_100(spd_100), .fdx(fdx), .lpbk(lpbk),
      .iso(iso), .coltest(coltest)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] best_of(input logic [3:0] c);
      if (c[3]) return 4'b1000;
      if (c[2]) return 4'b0100;
      if (c[1]) return 4'b0010;
      if (c[0]) return 4'b0001;
      return 4'b0000;
   endfunction

   task automatic bit_io(input logic b, input logic drv, output logic s, output logic oe);
      m_drv = drv;
      m_val = b;
      repeat (8) @(posedge clk);
      #1;
      s  = line;
      oe = mdio_oe;
      mdc = 1'b1;
      repeat (8) @(posedge clk);
      #1 mdc = 1'b0;
   endtask

   task automatic xfer(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, output logic [15:0] rdv,
                       output logic stray, output logic drv_ok);
      logic s, oe, want;
      logic [13:0] hd;
      want = rd && (pa == ADDR);
      stray = 1'b0; drv_ok = 1'b1; rdv = '0;
      hd = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
      for (int i = 0; i < 32; i++) begin bit_io(1'b1, 1'b1, s, oe); stray |= oe; end
      for (int i = 13; i >= 0; i--) begin bit_io(hd[i], 1'b1, s, oe); stray |= oe; end
      if (rd) begin
         bit_io(1'b1, 1'b0, s, oe); stray |= oe;
         bit_io(1'b1, 1'b0, s, oe);
         if (want) drv_ok &= (oe && s == 1'b0); else stray |= oe;
      end else begin
         bit_io(1'b1, 1'b1, s, oe); stray |= oe;
         bit_io(1'b0, 1'b1, s, oe); stray |= oe;
      end
      for (int i = 15; i >= 0; i--) begin
         bit_io(wd[i], !rd, s, oe);
         rdv[i] = s;
         if (want) drv_ok &= oe; else stray |= oe;
      end
      for (int i = 0; i < 2; i++) begin bit_io(1'b1, 1'b1, s, oe); stray |= oe; end
   endtask

   task automatic wr(input logic [4:0] ra, input logic [15:0] d);
      logic [15:0] v; logic st, ok;
      xfer(1'b0, ADDR, ra, d, v, st, ok);
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [4:0] ra, output logic [15:0] d);
      logic st, ok;
      xfer(1'b1, ADDR, ra, 16'h0, d, st, ok);
      check("R3 no drive outside read window", {15'b0, st}, 16'h0);
      check("R3 turnaround zero and data driven", {15'b0, ok}, 16'h1);
   endtask

   task automatic expect_reg(input string req, input logic [4:0] ra, input logic [15:0] e);
      logic [15:0] v;
      rd(ra, v);
      check(req, v, e);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] v, cw;
      logic st, ok;
      logic [3:0] a, b;
      void'($urandom(32'h5EED_0147));
      repeat (10) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R9 reset state of the outputs
      check("R9 reset outputs", {12'b0, mdio_oe, lpbk, iso, coltest}, 16'h0);
      expect_reg("R7 R9 negotiation running after reset", 5'd1, 16'h780D);
      repeat (NCYC + 20) @(posedge clk);
      expect_reg("R4 R9 status after auto negotiation", 5'd1, 16'h782D);
      expect_reg("R9 control default", 5'd0, 16'h3100);
      expect_reg("R4 id high", 5'd2, IDH);
      expect_reg("R4 id low", 5'd3, IDL);
      expect_reg("R4 unused address", 5'd7, 16'h0);
      expect_reg("R8 advertisement default", 5'd4, 16'h01E1);
      expect_reg("R8 partner register", 5'd5, 16'h4001 | (16'(best_of(4'hF & PARTNER)) << 5));
      check("R8 resolved mode pins", {14'b0, spd_100, fdx}, 16'h2);

      // R4 writes to read-only registers ignored
      wr(5'd2, 16'hFFFF);
      wr(5'd1, 16'h0000);
      expect_reg("R4 id high not writable", 5'd2, IDH);
      expect_reg("R4 status not writable", 5'd1, 16'h782D);

      // R2 foreign address: no write, no drive
      xfer(1'b0, ADDR ^ 5'd1, 5'd0, 16'h4400, v, st, ok);
      repeat (4) @(posedge clk);
      #1 check("R2 foreign write has no effect on pins", {14'b0, lpbk, iso}, 16'h0);
      expect_reg("R2 foreign write left control", 5'd0, 16'h3100);
      xfer(1'b1, ADDR ^ 5'd16, 5'd0, 16'h0, v, st, ok);
      check("R2 foreign read never drives", {15'b0, st}, 16'h0);
      check("R2 foreign read line idle", v, 16'hFFFF);

      // R5 R6 manual control with negotiation off
      for (int k = 0; k < 8; k++) begin
         cw = 16'($urandom()) & 16'h6580;
         wr(5'd0, cw);
         check("R5 loopback isolate coltest pins", {13'b0, lpbk, iso, coltest},
               {13'b0, cw[14], cw[10], cw[7]});
         check("R6 manual speed duplex pins", {14'b0, spd_100, fdx}, {14'b0, cw[13], cw[8]});
         expect_reg("R5 control readback", 5'd0, cw);
         if (k == 0) expect_reg("R6 no completion while disabled", 5'd1, 16'h780D);
      end

      // R7 R8 random and directed advertisements
      for (int k = 0; k < 9; k++) begin
         a = (k == 0) ? 4'b1001 : (k == 1) ? 4'b0001 : 4'($urandom());
         wr(5'd4, {7'b0, a, 5'b11111});
         expect_reg("R8 advertisement writable field", 5'd4, {7'b0, a, 5'b00001});
         wr(5'd0, 16'h1200);
         expect_reg("R7 complete low after restart", 5'd1, 16'h780D);
         expect_reg("R7 restart bit reads zero", 5'd0, 16'h1000);
         repeat (NCYC) @(posedge clk);
         expect_reg("R7 complete after countdown", 5'd1, 16'h782D);
         b = best_of(a & PARTNER);
         check("R8 negotiated speed duplex", {14'b0, spd_100, fdx},
               {14'b0, b[3] | b[2], b[3] | b[1]});
         expect_reg("R8 partner ability result", 5'd5, 16'h4001 | (16'(b) << 5));
      end

      // R10 soft reset
      wr(5'd0, 16'h4480);
      wr(5'd4, 16'h0020);
      wr(5'd0, 16'h8000);
      check("R10 pins cleared by soft reset", {13'b0, lpbk, iso, coltest}, 16'h0);
      expect_reg("R10 control restored", 5'd0, 16'h3100);
      expect_reg("R10 advertisement restored", 5'd4, 16'h01E1);
      repeat (NCYC) @(posedge clk);
      expect_reg("R10 negotiation rerun", 5'd1, 16'h782D);

      // R9 hardware reset restarts negotiation
      wr(5'd0, 16'h0400);
      #1 rst_n = 1'b0;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      check("R9 pins after hardware reset", {13'b0, lpbk, iso, coltest}, 16'h0);
      expect_reg("R9 negotiation restarted", 5'd1, 16'h780D);
      repeat (NCYC) @(posedge clk);
      expect_reg("R9 negotiation done again", 5'd1, 16'h782D);
      expect_reg("R1 write then read round trip", 5'd0, 16'h3100);
      wr(5'd0, 16'h7180);
      expect_reg("R1 write frame updates register", 5'd0, 16'h7180);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule